// File: doc/BRIEF.md
# Peripheral Low-Power Mode Controller

This block sequences a chipset's peripheral logic between full power, nap and sleep. It watches the core's "ready to quiesce" indication and a small set of control bits. When power management is enabled it parks the peripheral logic in one of the two low-power modes and acknowledges the quiesce to the core. From there it arbitrates among the wake sources and drives per-unit enables, a memory-refresh enable and a one-cycle pulse that asks the surrounding register logic to clear the power-management enable bit.

Nap keeps the PCI target path alive. A PCI memory transaction wakes the logic only for a while: the block enters a PCI-service mode and then drops back into nap, leaving the enable bit untouched. Any other wake source ends the low-power episode for good and requests that the enable bit be cleared. Sleep goes deeper. PCI traffic is not accepted there at all, and only a few monitoring units stay enabled.

Top module: `periph_pm_ctrl`

## Requirements
- R1: From full power, nap is entered at the next clock edge when `pm_en_i`=1, `core_rdy_i`=1, `sleep_sel_i`=0 and no clear pulse is outstanding.
- R2: Under the same conditions with `sleep_sel_i`=1, sleep is entered instead.
- R3: `qack_o` is 1 exactly while the mode is nap or sleep. It is 0 in full power and in PCI service.
- R4: A core wake in nap returns the block to full power at the next edge, which is within four cycles. A core wake is `cpu_bus_req_i`, `pic_int_i`, or `nmi_i` gated by `nmi_en_i`. In the same cycle `pm_clr_o` pulses high for exactly one cycle.
- R5: In nap, `pci_mem_req_i` without a core wake moves the block to PCI service with no clear pulse. With `pci_done_i`=1 and `pm_en_i`=1 it returns to nap. A core wake during PCI service goes to full power with a clear pulse.
- R6: If a PCI request and a core wake occur in the same cycle, the event is treated as a core wake.
- R7: `nmi_i` is not a wake source while `nmi_en_i`=0.
- R8: In sleep, `pci_mem_req_i` has no effect. Any core wake from sleep goes to full power and pulses `pm_clr_o`.
- R9: `unit_en_o` bit map: 0 arbiter, 1 refresh, 2 bus-request monitor, 3 NMI monitor, 4 interrupt controller, 5 I2C, 6 PCI target, 7 memory controller.
  - In full power and PCI service all bits are 1.
  - In nap, bits 0–6 are 1 and bit 7 is 0.
  - In sleep, bits 0–5 are 1 and bits 6–7 are 0.
  - In nap and sleep, bit 1 and `refresh_en_o` follow `lp_ref_en_i`.
- R10: `rst_ni` low forces full power asynchronously, with `qack_o`=0 and `pm_clr_o`=0.
- R11: `mode_o` encodes 00 full, 01 nap, 10 sleep, 11 PCI service.
- R12: While `pm_clr_o` is high, neither low-power mode is entered, even if `pm_en_i` is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, active low, asynchronous |
| pm_en_i | input | 1 | Power-management enable bit |
| sleep_sel_i | input | 1 | Select sleep instead of nap |
| nmi_en_i | input | 1 | Allow NMI as wake source |
| lp_ref_en_i | input | 1 | Keep refresh on in low-power modes |
| core_rdy_i | input | 1 | Core ready to nap or sleep |
| pci_mem_req_i | input | 1 | PCI transaction to system memory |
| pci_done_i | input | 1 | PCI transaction completed |
| cpu_bus_req_i | input | 1 | Processor bus request |
| nmi_i | input | 1 | Non-maskable interrupt |
| pic_int_i | input | 1 | Interrupt controller output |
| qack_o | output | 1 | Quiesce acknowledge to core |
| unit_en_o | output | NUM_UNITS | Per-unit enables |
| refresh_en_o | output | 1 | Memory refresh enable |
| pm_clr_o | output | 1 | One-cycle request to clear enable bit |
| mode_o | output | 2 | Current mode |

## Verification
The bench drives a PCI request together with a bus request in the same nap cycle. A design that gives PCI priority would sit in PCI service and never clear the enable bit. It keeps `pm_en_i` high in the cycle after a clear pulse, the way a register lags by one cycle. A controller without the re-entry guard would drop straight back into nap. It also drives PCI requests in sleep, where a careless arbiter would wake, and NMI with its enable off, where an ungated NMI would wake the block. Unit enables are read in nap and sleep with the refresh bit both ways, and reset is pulled low in mid-cycle during sleep. A synchronous reset would leave `mode_o` at sleep until the next edge.

// File: rtl/periph_pm_pkg.sv
package periph_pm_pkg;
  typedef enum logic [1:0] {
    M_FULL  = 2'b00,
    M_NAP   = 2'b01,
    M_SLEEP = 2'b10,
    M_PCI   = 2'b11
  } pm_mode_e;

  typedef struct packed {
    logic core;  // bus req, int, gated nmi
    logic pci;   // pci only, no core wake this cycle
  } wake_t;
endpackage

// File: rtl/periph_pm_wake.sv
module periph_pm_wake
  import periph_pm_pkg::*;
(
  input  logic  pci_mem_req_i,
  input  logic  cpu_bus_req_i,
  input  logic  nmi_i,
  input  logic  nmi_en_i,
  input  logic  pic_int_i,
  output wake_t wake_o
);
  always_comb begin
    wake_o.core = cpu_bus_req_i | pic_int_i | (nmi_i & nmi_en_i);
    wake_o.pci  = pci_mem_req_i & ~wake_o.core;  // core wins a tie
  end
endmodule

// File: rtl/periph_pm_fsm.sv
module periph_pm_fsm
  import periph_pm_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pm_en_i,
  input  logic     sleep_sel_i,
  input  logic     core_rdy_i,
  input  logic     pci_done_i,
  input  wake_t    wake_i,
  output pm_mode_e mode_o,
  output logic     clr_o
);
  pm_mode_e state_q, state_d;
  logic     clr_q, clr_d;

  always_comb begin
    state_d = state_q;
    clr_d   = 1'b0;
    unique case (state_q)
      M_FULL: begin
        if (pm_en_i && core_rdy_i && !clr_q)
          state_d = sleep_sel_i ? M_SLEEP : M_NAP;
      end
      M_NAP: begin
        if (wake_i.core) begin
          state_d = M_FULL;
          clr_d   = 1'b1;
        end else if (wake_i.pci) begin
          state_d = M_PCI;
        end
      end
      M_PCI: begin
        if (wake_i.core) begin
          state_d = M_FULL;
          clr_d   = 1'b1;
        end else if (pci_done_i) begin
          state_d = pm_en_i ? M_NAP : M_FULL;
        end
      end
      M_SLEEP: begin
        if (wake_i.core) begin
          state_d = M_FULL;
          clr_d   = 1'b1;
        end
      end
      default: state_d = M_FULL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_FULL;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      clr_q   <= clr_d;
    end
  end

  assign mode_o = state_q;
  assign clr_o  = clr_q;

  assert_nap_entry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_NAP && $past(state_q) == M_FULL)
      |-> $past(pm_en_i && core_rdy_i && !sleep_sel_i));

  assert_sleep_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_SLEEP && $past(state_q) == M_FULL)
      |-> $past(pm_en_i && core_rdy_i && sleep_sel_i));

  assert_core_wake_nap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_NAP && wake_i.core) |=> (state_q == M_FULL && clr_q));

  assert_clr_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> !clr_q);

  assert_pci_service_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_NAP && wake_i.pci) |=> (state_q == M_PCI && !clr_q));

  assert_sleep_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == M_SLEEP && !wake_i.core) |=> state_q == M_SLEEP);

  assert_no_reentry_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> state_q == M_FULL);
endmodule

// File: rtl/periph_pm_gate.sv
module periph_pm_gate
  import periph_pm_pkg::*;
#(
  parameter int                   NUM_UNITS  = 8,
  parameter int                   REF_IDX    = 1,
  parameter logic [NUM_UNITS-1:0] NAP_KEEP   = 8'h7F,
  parameter logic [NUM_UNITS-1:0] SLEEP_KEEP = 8'h3F
) (
  input  pm_mode_e             mode_i,
  input  logic                 lp_ref_en_i,
  output logic [NUM_UNITS-1:0] unit_en_o
);
  logic full_pwr;
  assign full_pwr = (mode_i == M_FULL) || (mode_i == M_PCI);

  for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
    logic keep;
    assign keep = full_pwr
                | ((mode_i == M_NAP)   & NAP_KEEP[g])
                | ((mode_i == M_SLEEP) & SLEEP_KEEP[g]);
    if (g == REF_IDX) begin : g_ref
      assign unit_en_o[g] = keep & (full_pwr | lp_ref_en_i);
    end else begin : g_plain
      assign unit_en_o[g] = keep;
    end
  end

  always_comb begin
    if (mode_i == M_SLEEP)
      assert_sleep_gate_R9: assert ((unit_en_o & ~SLEEP_KEEP) == '0);
  end
endmodule

// File: rtl/periph_pm_ctrl.sv
module periph_pm_ctrl
  import periph_pm_pkg::*;
#(
  parameter int                   NUM_UNITS  = 8,
  parameter int                   REF_IDX    = 1,
  parameter logic [NUM_UNITS-1:0] NAP_KEEP   = 8'h7F,
  parameter logic [NUM_UNITS-1:0] SLEEP_KEEP = 8'h3F
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pm_en_i,
  input  logic                 sleep_sel_i,
  input  logic                 nmi_en_i,
  input  logic                 lp_ref_en_i,
  input  logic                 core_rdy_i,
  input  logic                 pci_mem_req_i,
  input  logic                 pci_done_i,
  input  logic                 cpu_bus_req_i,
  input  logic                 nmi_i,
  input  logic                 pic_int_i,
  output logic                 qack_o,
  output logic [NUM_UNITS-1:0] unit_en_o,
  output logic                 refresh_en_o,
  output logic                 pm_clr_o,
  output logic [1:0]           mode_o
);
  wake_t    wake;
  pm_mode_e mode;

  periph_pm_wake u_wake (
    .pci_mem_req_i (pci_mem_req_i),
    .cpu_bus_req_i (cpu_bus_req_i),
    .nmi_i         (nmi_i),
    .nmi_en_i      (nmi_en_i),
    .pic_int_i     (pic_int_i),
    .wake_o        (wake)
  );

  periph_pm_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pm_en_i     (pm_en_i),
    .sleep_sel_i (sleep_sel_i),
    .core_rdy_i  (core_rdy_i),
    .pci_done_i  (pci_done_i),
    .wake_i      (wake),
    .mode_o      (mode),
    .clr_o       (pm_clr_o)
  );

  periph_pm_gate #(
    .NUM_UNITS  (NUM_UNITS),
    .REF_IDX    (REF_IDX),
    .NAP_KEEP   (NAP_KEEP),
    .SLEEP_KEEP (SLEEP_KEEP)
  ) u_gate (
    .mode_i      (mode),
    .lp_ref_en_i (lp_ref_en_i),
    .unit_en_o   (unit_en_o)
  );

  assign qack_o       = (mode == M_NAP) || (mode == M_SLEEP);
  assign refresh_en_o = unit_en_o[REF_IDX];
  assign mode_o       = mode;

  assert_qack_pci_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(qack_o) && wake.pci && !sleep_sel_i && mode == M_NAP) |=> !qack_o);

  assert_refresh_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qack_o |-> refresh_en_o);
endmodule

// File: tb/tb_periph_pm_ctrl.sv
module tb_periph_pm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;
  // {pm, sl, rdy, nmi_en | pci, done, bus, nmi, pic | mode[2] | qack | clr}
  localparam logic [12:0] VEC [NV] = '{
    13'b0010_00000_00_0_0,  // R1 pm off: stay full
    13'b1000_00000_00_0_0,  // R1 core not ready
    13'b1010_00000_01_1_0,  // R1 R3 enter nap
    13'b1000_00000_01_1_0,  // R3 hold nap
    13'b1000_10000_11_0_0,  // R5 pci wake -> service
    13'b1000_00000_11_0_0,  // R5 service in progress
    13'b1000_01000_01_1_0,  // R5 done -> nap, no clr
    13'b1000_00010_01_1_0,  // R7 nmi gated off
    13'b1001_00010_00_0_1,  // R4 nmi wake, clr pulse
    13'b0010_00000_00_0_0,  // R4 pulse ends
    13'b1010_00000_01_1_0,  // R1 re-enter nap
    13'b1000_10100_00_0_1,  // R6 pci + bus req same cycle
    13'b1010_00000_00_0_0,  // R12 pm still set during pulse
    13'b1110_00000_10_1_0,  // R2 enter sleep
    13'b1100_10000_10_1_0,  // R8 pci ignored in sleep
    13'b1100_00001_00_0_1,  // R8 int wakes sleep, clr
    13'b0000_00000_00_0_0,  // R11 full
    13'b1010_00000_01_1_0,  // R1 nap
    13'b1000_10000_11_0_0,  // R5 service
    13'b1000_00100_00_0_1   // R5 core wake during service
  };

  logic clk = 0, rst_n = 0;
  logic pm_en = 0, sleep_sel = 0, nmi_en = 0, lp_ref = 1, core_rdy = 0;
  logic pci_req = 0, pci_done = 0, bus_req = 0, nmi = 0, pic = 0;
  logic qack, refresh_en, pm_clr;
  logic [7:0] unit_en;
  logic [1:0] mode;
  int total = 0, bad = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_pm_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .pm_en_i(pm_en), .sleep_sel_i(sleep_sel),
    .nmi_en_i(nmi_en), .lp_ref_en_i(lp_ref), .core_rdy_i(core_rdy),
    .pci_mem_req_i(pci_req), .pci_done_i(pci_done), .cpu_bus_req_i(bus_req),
    .nmi_i(nmi), .pic_int_i(pic), .qack_o(qack), .unit_en_o(unit_en),
    .refresh_en_o(refresh_en), .pm_clr_o(pm_clr), .mode_o(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [8:0] v);
    {pm_en, sleep_sel, core_rdy, nmi_en, pci_req, pci_done, bus_req, nmi, pic} = v;
  endtask

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R10 reset state
    chk("R10 mode", mode, 2'b00);
    chk("R10 qack", qack, 0);
    chk("R10 clr", pm_clr, 0);
    chk("R9 full enables", unit_en, 8'hFF);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][12:4]);
      step();
      chk($sformatf("R11 mode row%0d", i), mode, VEC[i][3:2]);
      chk($sformatf("R3 qack row%0d", i), qack, VEC[i][1]);
      chk($sformatf("R4 clr row%0d", i), pm_clr, VEC[i][0]);
    end

    // R9 sleep gating, refresh both ways
    @(negedge clk); drive(9'b0000_00000); lp_ref = 0;
    @(negedge clk); drive(9'b1110_00000);
    step();
    chk("R2 sleep", mode, 2'b10);
    chk("R9 sleep enables noref", unit_en, 8'h3D);
    chk("R9 refresh off", refresh_en, 0);
    @(negedge clk); lp_ref = 1; #1;
    chk("R9 sleep enables ref", unit_en, 8'h3F);
    chk("R9 refresh on", refresh_en, 1);

    // R10 asynchronous reset mid-cycle in sleep
    @(negedge clk); #1 rst_n = 0; #1;
    chk("R10 async mode", mode, 2'b00);
    chk("R10 async qack", qack, 0);
    @(negedge clk); rst_n = 1; drive(9'b0000_00000);

    // R9 nap gating without refresh
    @(negedge clk); lp_ref = 0; drive(9'b1010_00000);
    step();
    chk("R1 nap", mode, 2'b01);
    chk("R9 nap enables noref", unit_en, 8'h7D);
    @(negedge clk); drive(9'b1000_10000);
    step();
    chk("R9 service enables", unit_en, 8'hFF);
    // R5 done with pm cleared -> full
    @(negedge clk); drive(9'b0000_01000);
    step();
    chk("R5 done pm off", mode, 2'b00);
    chk("R5 no clr", pm_clr, 0);

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule